// File: doc/BRIEF.md
# Level-2 Cache Controller Register Stub

This block is a register-only stand-in for a level-2 cache controller. System software sees the usual controller programming window: an identification word, a cache-type word, an enable bit, auxiliary settings, RAM latency settings and an address-filter range. No caching takes place behind it. Software that polls maintenance operations always finds them finished, so boot code that expects a real controller runs to the end without stalling.

Access uses a plain single-cycle strobe bus. An address, a write enable with write data, and a read enable are sampled on a rising clock edge. Read data and an error flag come back registered one cycle later. Only the low twelve address bits select a register, so the block mirrors itself every 4 KiB.

The cache-type word is held in a register. Each read of it merges way-size and associativity bits from the auxiliary register into that held word. Bits that have been merged in are never cleared until reset.

Top module: `l2c_regstub`

## Requirements
- R1: A read at offset 0x000 returns 0x410000C8.
- R2: Only address bits 11:0 select a register; for example, address 0x5104 reaches the same register as 0x104.
- R3: A write to offset 0x100 keeps only write-data bit 0. Reads of 0x100 return that bit in bit 0, with bits 31:1 zero.
- R4: Offsets 0x104 (auxiliary), 0x108 (tag latency), 0x10C (data latency), 0xC00 (filter low) and 0xC04 (filter high) each hold a full 32-bit value that reads back as written.
- R5: After reset, the auxiliary register reads 0x02020000. The 0x100, 0x108, 0x10C, 0xC00 and 0xC04 registers read zero. The held cache-type word returns to its parameter, which defaults to 0x1C100100.
- R6: A read at 0x004 forms a 5-bit code as follows: bits 4:2 = auxiliary bits 19:17, bit 1 = 0, bit 0 = auxiliary bit 16. The read ORs the code into the held word at bits 22:18 and at bits 10:6, stores the result and returns it. Merged bits remain set even after the auxiliary register changes.
- R7: Offsets 0x730 through 0x7FF read zero and ignore writes, with no error.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read zero and ignore writes, with no error.
- R9: An access to any other offset reads zero, changes no register and sets the error output for exactly the one cycle after the strobe. The error output is zero in every other cycle.
- R10: Read data appears in the cycle after the read strobe and is zero in any cycle that follows a cycle without a read strobe.
- R11: When a write and a read to 0x104 share a cycle, the read returns the old value. The next cache-type read uses the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Access address; bits 11:0 decoded |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle flag for an access to an unmapped offset |

## Verification
The cache-type merge is tried three ways. First it is read with the reset auxiliary value, whose code bits are already present in the held word, so the word must not change. Next the auxiliary register has bits 19:16 all set, which shows whether the zero gap at code bit 1 and both target positions are placed correctly. Finally the auxiliary register is cleared and the word is read again, which separates a sticky merge from one that is recomputed on every read. The decode is tried at the edges of the maintenance window (0x72C, 0x730, 0x7FC, 0x800), at aliased high addresses and at silent offsets, which separates the three kinds of offset: silent, mapped and faulting. A write and a read to the auxiliary register in the same cycle, done after a fresh reset, shows whether the read returns the old value while the next cache-type read uses the new one.

// File: rtl/l2c_regstub_pkg.sv
package l2c_regstub_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 12;

  localparam logic [DATA_W-1:0] ID_WORD  = 32'h4100_00C8;
  localparam logic [DATA_W-1:0] AUX_RST  = 32'h0202_0000;

  localparam logic [OFF_W-1:0] OFF_ID     = 12'h000;
  localparam logic [OFF_W-1:0] OFF_CTYPE  = 12'h004;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h100;
  localparam logic [OFF_W-1:0] OFF_AUX    = 12'h104;
  localparam logic [OFF_W-1:0] OFF_TAGLAT = 12'h108;
  localparam logic [OFF_W-1:0] OFF_DATLAT = 12'h10C;
  localparam logic [OFF_W-1:0] OFF_FLT_LO = 12'hC00;
  localparam logic [OFF_W-1:0] OFF_FLT_HI = 12'hC04;
  localparam logic [OFF_W-1:0] OFF_SIL_A  = 12'hF40;
  localparam logic [OFF_W-1:0] OFF_SIL_B  = 12'hF60;
  localparam logic [OFF_W-1:0] OFF_SIL_C  = 12'hF80;
  localparam logic [OFF_W-1:0] MAINT_LO   = 12'h730;
  localparam logic [OFF_W-1:0] MAINT_HI   = 12'h800;

  // cache-type merge geometry
  localparam int CODE_W = 5;
  localparam int POS_HI = 18;
  localparam int POS_LO = 6;

  typedef enum logic [3:0] {
    SEL_ID, SEL_CTYPE, SEL_CTRL, SEL_AUX, SEL_TAGLAT, SEL_DATLAT,
    SEL_FLT_LO, SEL_FLT_HI, SEL_MAINT, SEL_SILENT, SEL_BAD
  } sel_e;

  // full-width registers, in storage order
  localparam int NFULL    = 5;
  localparam int FULL_AUX = 0;

  function automatic sel_e full_sel(input int idx);
    case (idx)
      0:       return SEL_AUX;
      1:       return SEL_TAGLAT;
      2:       return SEL_DATLAT;
      3:       return SEL_FLT_LO;
      default: return SEL_FLT_HI;
    endcase
  endfunction
endpackage

// File: rtl/l2c_addr_decode.sv
module l2c_addr_decode
  import l2c_regstub_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  output sel_e             sel
);
  always_comb begin
    if (off >= MAINT_LO && off < MAINT_HI) begin
      sel = SEL_MAINT;
    end else begin
      case (off)
        OFF_ID:     sel = SEL_ID;
        OFF_CTYPE:  sel = SEL_CTYPE;
        OFF_CTRL:   sel = SEL_CTRL;
        OFF_AUX:    sel = SEL_AUX;
        OFF_TAGLAT: sel = SEL_TAGLAT;
        OFF_DATLAT: sel = SEL_DATLAT;
        OFF_FLT_LO: sel = SEL_FLT_LO;
        OFF_FLT_HI: sel = SEL_FLT_HI;
        OFF_SIL_A,
        OFF_SIL_B,
        OFF_SIL_C:  sel = SEL_SILENT;
        default:    sel = SEL_BAD;
      endcase
    end
  end
endmodule

// File: rtl/l2c_cfg_regs.sv
module l2c_cfg_regs
  import l2c_regstub_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  sel_e                         sel,
  input  logic [DATA_W-1:0]            wdata,
  output logic                         enable_o,
  output logic [NFULL-1:0][DATA_W-1:0] full_o
);
  // single-bit enable register
  always_ff @(posedge clk) begin
    if (rst)                          enable_o <= 1'b0;
    else if (we && sel == SEL_CTRL)   enable_o <= wdata[0];
  end

  // full-width registers
  for (genvar i = 0; i < NFULL; i++) begin : g_full
    localparam logic [DATA_W-1:0] RV = (i == FULL_AUX) ? AUX_RST : '0;
    always_ff @(posedge clk) begin
      if (rst)                           full_o[i] <= RV;
      else if (we && sel == full_sel(i)) full_o[i] <= wdata;
    end
  end

  // R4
  aux_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_AUX) |=> full_o[FULL_AUX] == $past(wdata));

  // R5
  reset_val_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (full_o[FULL_AUX] == AUX_RST && !enable_o));
endmodule

// File: rtl/l2c_ctype_hold.sv
module l2c_ctype_hold
  import l2c_regstub_pkg::*;
#(
  parameter logic [DATA_W-1:0] CTYPE_RST = 32'h1C10_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] aux,
  output logic [DATA_W-1:0] merged_o
);
  logic [DATA_W-1:0] held_q;
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] code_ext;

  assign code     = {aux[19:17], 1'b0, aux[16]};
  assign code_ext = {{(DATA_W-CODE_W){1'b0}}, code};
  assign merged_o = held_q | (code_ext << POS_HI) | (code_ext << POS_LO);

  always_ff @(posedge clk) begin
    if (rst)         held_q <= CTYPE_RST;
    else if (rd_hit) held_q <= merged_o;
  end

  // R6
  sticky_bits_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((held_q & $past(held_q)) == $past(held_q)));
endmodule

// File: rtl/l2c_regstub.sv
module l2c_regstub
  import l2c_regstub_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [DATA_W-1:0] CTYPE_RST = 32'h1C10_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err
);
  logic [OFF_W-1:0]            off;
  logic                        unused_hi;
  sel_e                        sel;
  logic                        enable_q;
  logic [NFULL-1:0][DATA_W-1:0] full_q;
  logic [DATA_W-1:0]           ctype_merged;

  assign off       = bus_addr[OFF_W-1:0];
  assign unused_hi = ^bus_addr[ADDR_W-1:OFF_W];

  l2c_addr_decode u_dec (.off(off), .sel(sel));

  l2c_cfg_regs u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wdata(bus_wdata),
    .enable_o(enable_q), .full_o(full_q)
  );

  l2c_ctype_hold #(.CTYPE_RST(CTYPE_RST)) u_ctype (
    .clk(clk), .rst(rst), .rd_hit(bus_re && sel == SEL_CTYPE),
    .aux(full_q[FULL_AUX]), .merged_o(ctype_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= (bus_re || bus_we) && sel == SEL_BAD;
      if (bus_re) begin
        case (sel)
          SEL_ID:     bus_rdata <= ID_WORD;
          SEL_CTYPE:  bus_rdata <= ctype_merged;
          SEL_CTRL:   bus_rdata <= {{(DATA_W-1){1'b0}}, enable_q};
          SEL_AUX:    bus_rdata <= full_q[0];
          SEL_TAGLAT: bus_rdata <= full_q[1];
          SEL_DATLAT: bus_rdata <= full_q[2];
          SEL_FLT_LO: bus_rdata <= full_q[3];
          SEL_FLT_HI: bus_rdata <= full_q[4];
          default:    bus_rdata <= '0;
        endcase
      end else begin
        bus_rdata <= '0;
      end
    end
  end

  // R1
  id_word_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && off == OFF_ID) |=> bus_rdata == ID_WORD);

  // R3
  ctrl_width_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && off == OFF_CTRL) |=> bus_rdata[DATA_W-1:1] == '0);

  // R7
  maint_done_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && off >= MAINT_LO && off < MAINT_HI) |=> (bus_rdata == '0 && !bus_err));

  // R9
  bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_re || bus_we) && sel == SEL_BAD) |=> (bus_err && bus_rdata == '0));

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_re || bus_we) |=> !bus_err);

  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> bus_rdata == '0);
endmodule

// File: tb/tb_l2c_regstub.sv
`timescale 1ns/100ps
module tb_l2c_regstub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  l2c_regstub dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_err(bus_err)
  );

  typedef struct packed {
    logic        we;
    logic        re;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        exp_err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 32'h0000_0000, 32'h0, 32'h4100_00C8, 1'b0, 8'd1},  // R1
    '{1'b0, 1'b1, 32'h0000_0004, 32'h0, 32'h1C10_0100, 1'b0, 8'd6},  // R6 reset aux
    '{1'b0, 1'b1, 32'h0000_0104, 32'h0, 32'h0202_0000, 1'b0, 8'd5},  // R5
    '{1'b0, 1'b1, 32'h0000_0100, 32'h0, 32'h0000_0000, 1'b0, 8'd5},  // R5
    '{1'b0, 1'b1, 32'h0000_0C04, 32'h0, 32'h0000_0000, 1'b0, 8'd5},  // R5
    '{1'b1, 1'b0, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd10}, // R10 write only
    '{1'b0, 1'b1, 32'h0000_0100, 32'h0, 32'h0000_0001, 1'b0, 8'd3},  // R3
    '{1'b1, 1'b0, 32'h0000_0100, 32'hFFFF_FFFE, 32'h0, 1'b0, 8'd3},  // R3
    '{1'b0, 1'b1, 32'h0000_0100, 32'h0, 32'h0000_0000, 1'b0, 8'd3},  // R3
    '{1'b1, 1'b0, 32'h0000_0108, 32'hA5A5_5A5A, 32'h0, 1'b0, 8'd4},  // R4
    '{1'b0, 1'b1, 32'h0000_0108, 32'h0, 32'hA5A5_5A5A, 1'b0, 8'd4},  // R4
    '{1'b1, 1'b0, 32'h0000_010C, 32'h1357_2468, 32'h0, 1'b0, 8'd4},  // R4
    '{1'b0, 1'b1, 32'h0000_010C, 32'h0, 32'h1357_2468, 1'b0, 8'd4},  // R4
    '{1'b1, 1'b0, 32'h0000_0C00, 32'hDEAD_BEEF, 32'h0, 1'b0, 8'd4},  // R4
    '{1'b1, 1'b0, 32'h0000_0C04, 32'h1234_5678, 32'h0, 1'b0, 8'd4},  // R4
    '{1'b0, 1'b1, 32'h0000_0C00, 32'h0, 32'hDEAD_BEEF, 1'b0, 8'd4},  // R4
    '{1'b0, 1'b1, 32'h0000_0C04, 32'h0, 32'h1234_5678, 1'b0, 8'd4},  // R4
    '{1'b1, 1'b0, 32'h0000_5104, 32'h000F_0000, 32'h0, 1'b0, 8'd2},  // R2 alias
    '{1'b0, 1'b1, 32'hFFFF_F104, 32'h0, 32'h000F_0000, 1'b0, 8'd2},  // R2 alias
    '{1'b0, 1'b1, 32'h0000_0004, 32'h0, 32'h1C74_0740, 1'b0, 8'd6},  // R6 all code bits
    '{1'b1, 1'b0, 32'h0000_0104, 32'h0000_0000, 32'h0, 1'b0, 8'd6},  // R6
    '{1'b0, 1'b1, 32'h0000_0004, 32'h0, 32'h1C74_0740, 1'b0, 8'd6},  // R6 sticky
    '{1'b1, 1'b0, 32'h0000_0730, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd7},  // R7
    '{1'b1, 1'b1, 32'h0000_07FC, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd7},  // R7
    '{1'b0, 1'b1, 32'h0000_0800, 32'h0, 32'h0000_0000, 1'b1, 8'd9},  // R9 above window
    '{1'b0, 1'b1, 32'h0000_072C, 32'h0, 32'h0000_0000, 1'b1, 8'd9},  // R9 below window
    '{1'b1, 1'b1, 32'h0000_0F40, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd8},  // R8
    '{1'b1, 1'b0, 32'h0000_0F60, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd8},  // R8
    '{1'b1, 1'b0, 32'h0000_0200, 32'hFFFF_FFFF, 32'h0, 1'b1, 8'd9},  // R9 bad write
    '{1'b0, 1'b1, 32'h0000_0108, 32'h0, 32'hA5A5_5A5A, 1'b0, 8'd9}   // R9/R7/R8 no change
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // one access: drive at negedge, sampled at posedge, results read at next negedge
  task automatic access(input logic we, input logic re, input logic [31:0] addr,
                        input logic [31:0] wd);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = addr; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R5 / R10: outputs idle after reset
    @(negedge clk);
    check(5, "rdata after reset", bus_rdata, 32'h0);
    check(9, "err after reset", {31'b0, bus_err}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].we, VECS[i].re, VECS[i].addr, VECS[i].wdata);
      check(VECS[i].req, $sformatf("vec %0d rdata", i), bus_rdata, VECS[i].exp);
      check(VECS[i].req, $sformatf("vec %0d err", i), {31'b0, bus_err},
            {31'b0, VECS[i].exp_err});
    end

    // R9 / R10: one-cycle pulse and data cleared in following idle cycle
    access(1'b0, 1'b1, 32'h0000_0300, 32'h0);
    check(9, "bad read err", {31'b0, bus_err}, 32'h1);
    @(negedge clk);
    check(9, "err drops next cycle", {31'b0, bus_err}, 32'h0);
    access(1'b0, 1'b1, 32'h0000_0000, 32'h0);
    check(10, "id read", bus_rdata, 32'h4100_00C8);
    @(negedge clk);
    check(10, "rdata zero when idle", bus_rdata, 32'h0);

    // R5: reset restores cache-type word and registers
    do_reset();
    access(1'b0, 1'b1, 32'h0000_0004, 32'h0);
    check(5, "ctype after reset", bus_rdata, 32'h1C10_0100);
    access(1'b0, 1'b1, 32'h0000_0C00, 32'h0);
    check(5, "filter low after reset", bus_rdata, 32'h0);
    access(1'b0, 1'b1, 32'h0000_0108, 32'h0);
    check(5, "tag latency after reset", bus_rdata, 32'h0);

    // R11: same-cycle write and read of auxiliary
    access(1'b1, 1'b1, 32'h0000_0104, 32'h0008_0000);
    check(11, "same-cycle aux read old", bus_rdata, 32'h0202_0000);
    access(1'b0, 1'b1, 32'h0000_0004, 32'h0);
    check(11, "ctype uses new aux", bus_rdata, 32'h1C50_0500);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule